// File: doc/BRIEF.md
# Input Overvoltage Fault Response Controller

This block decides what a power converter does when its input supply goes over voltage. It holds one 8-bit configuration byte. A synchronous fault flag, a per-switching-cycle tick and a soft-start-period tick drive a small state machine, which controls the converter-run output. The byte sets three things: how the block reacts to the fault (ignore it, shut down after a short count of switching cycles, or shut down at once), how many restarts it tries before it latches off, and the length of both the shutdown delay and the hiccup wait before each restart.

The enable command powers the converter up. Dropping the enable command abandons any fault sequence in progress. A start-up-complete flag with no fault present marks a restart attempt as successful. Each byte written to the configuration port is checked. A byte with the unsupported response code is refused, which sets a status flag and pulses an alert to the host.

Top module: `ovp_resp_ctrl`

## Requirements
- R1: A write whose bits 7:6 are not 11 stores the byte on the next edge, and `cfg_o` shows it. Bits 7:6 select the response: 00 ignore, 01 delayed, 10 immediate. Bits 5:3 hold the retry count. Bits 2:0 hold the timing code. The reset value is 8'h92.
- R2: A write whose bits 7:6 are 11 leaves the stored byte unchanged. It sets `cfg_err_o`, which stays high until the next accepted write clears it, and pulses `cfg_alert_o` high for one cycle.
- R3: With response 00, a fault while running leaves `run_o` high.
- R4: With response 01, the converter keeps running while it counts switching-cycle ticks. It shuts down on the tick that reaches the delay length, provided the fault is still high on that tick. The delay length is 1 tick for codes 0–1, 3 ticks for codes 2–4 and 7 ticks for codes 5–7.
- R5: If the fault drops during the delay count, the count is discarded and running continues.
- R6: With response 10, `run_o` is low in the cycle after the fault is first seen while running.
- R7: A retry count of 0 latches off at the first shutdown: `latched_off_o` goes high and `run_o` stays low.
- R8: A retry count N from 1 to 6 allows N restart attempts, then latches off. An attempt made while the fault is high counts toward N and keeps `run_o` low.
- R9: A retry count of 7 retries without limit and never latches off.
- R10: Each restart attempt follows a hiccup wait. The wait is 1 soft-start tick for code 0 and N ticks for any other code N.
- R11: During an attempt, `startup_done_i` with no fault returns the block to running and clears the attempt count.
- R12: When `enable_i` is low, the next cycle has `run_o` and `latched_off_o` low and the attempt count cleared. When `enable_i` is high in idle, `run_o` goes high on the next cycle.
- R13: Response, retry count and timing code are sampled when a fault is detected while running. A write made later in that sequence does not change the sequence under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write byte |
| cfg_o | output | 8 | Stored configuration byte |
| cfg_err_o | output | 1 | Status flag: last write refused |
| cfg_alert_o | output | 1 | One-cycle host alert on a refused write |
| enable_i | input | 1 | ON command |
| fault_i | input | 1 | Synchronous input-overvoltage flag |
| sw_tick_i | input | 1 | One pulse per switching cycle |
| ss_tick_i | input | 1 | One pulse per soft-start period |
| startup_done_i | input | 1 | Start-up complete flag |
| run_o | output | 1 | Converter run command |
| latched_off_o | output | 1 | Converter latched off |

## Verification
The hardest case to reach is the latch-off that follows a run of restart attempts made while the fault never clears. Here every attempt is hidden: `run_o` stays low, so only the attempt count tells one attempt from the next. The bench holds the fault high through several hiccup waits with a finite retry count, and compares the cycle of latch-off with a behavioural model. It also drops the fault inside a hiccup wait with unlimited retry, then confirms that a clean start-up resets the count, so a later fault is given its full allowance of attempts again.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  localparam int CFG_W = 8;
  localparam int FLD_W = 3;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    MODE_IGNORE    = 2'b00,
    MODE_DELAYED   = 2'b01,
    MODE_IMMEDIATE = 2'b10,
    MODE_BAD       = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_DELAY, ST_HICCUP, ST_START, ST_LATCH
  } state_e;

  localparam logic [FLD_W-1:0] RETRY_NONE    = '0;
  localparam logic [FLD_W-1:0] RETRY_FOREVER = '1;
endpackage

// File: rtl/ovp_cfg_reg.sv
module ovp_cfg_reg
  import ovp_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = 8'h92
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             err_o,
  output logic             alert_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             err_q, alert_q;
  logic             bad_w;

  assign bad_w = (wdata_i[CFG_W-1 -: 2] == MODE_BAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= RST_VAL;
      err_q   <= 1'b0;
      alert_q <= 1'b0;
    end else begin
      alert_q <= we_i && bad_w;
      if (we_i) begin
        if (bad_w) begin
          err_q <= 1'b1;
        end else begin
          cfg_q <= wdata_i;
          err_q <= 1'b0;
        end
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign err_o   = err_q;
  assign alert_o = alert_q;

  assert_bad_write_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && bad_w |=> cfg_o == $past(cfg_o) && err_o && alert_o);
  assert_good_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !bad_w |=> cfg_o == $past(wdata_i) && !err_o);
  assert_alert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o && !we_i |=> !alert_o);
endmodule

// File: rtl/ovp_cfg_decode.sv
module ovp_cfg_decode
  import ovp_pkg::*;
(
  input  logic [FLD_W-1:0] code_i,
  output logic [CNT_W-1:0] dly_len_o,
  output logic [CNT_W-1:0] hic_len_o
);
  // delay groups: {0,1}->1, {2..4}->3, {5..7}->7
  always_comb begin
    if (code_i < FLD_W'(2))      dly_len_o = CNT_W'(1);
    else if (code_i < FLD_W'(5)) dly_len_o = CNT_W'(3);
    else                         dly_len_o = CNT_W'(7);
    hic_len_o = (code_i == '0) ? CNT_W'(1) : CNT_W'(code_i);
  end
endmodule

// File: rtl/ovp_tick_timer.sv
module ovp_tick_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] nxt_w;

  assign nxt_w  = {1'b0, cnt_q} + EXT_W'(1);
  assign done_o = tick_i && (nxt_w >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt_w[CNT_W-1:0];
  end
endmodule

// File: rtl/ovp_fsm.sv
module ovp_fsm
  import ovp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             fault_i,
  input  logic             sw_tick_i,
  input  logic             ss_tick_i,
  input  logic             startup_done_i,
  input  logic [1:0]       mode_i,
  input  logic [FLD_W-1:0] retry_i,
  input  logic [FLD_W-1:0] code_i,
  input  logic [CNT_W-1:0] dly_len_i,
  input  logic [CNT_W-1:0] hic_len_i,
  input  logic             tmr_done_i,
  output logic [FLD_W-1:0] code_snap_o,
  output logic             tmr_tick_o,
  output logic             tmr_clr_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             run_o,
  output logic             latched_o
);
  state_e           state_q, state_d;
  logic [FLD_W-1:0] retry_s, code_s, att_q, att_d;
  logic             limit_hit;
  state_e           shut_st;

  assign limit_hit = (retry_s == RETRY_NONE) ||
                     ((retry_s != RETRY_FOREVER) && (att_q >= retry_s));
  assign shut_st   = limit_hit ? ST_LATCH : ST_HICCUP;

  assign tmr_tick_o = ((state_q == ST_DELAY) && sw_tick_i) ||
                      ((state_q == ST_HICCUP) && ss_tick_i);
  assign tmr_len_o  = (state_q == ST_DELAY) ? dly_len_i : hic_len_i;
  assign tmr_clr_o  = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    att_d   = att_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
      att_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_RUN;
          att_d   = '0;
        end
        ST_RUN: if (fault_i) begin
          // attempt count is zero here, so only the live retry field matters
          if (mode_i == MODE_DELAYED)        state_d = ST_DELAY;
          else if (mode_i == MODE_IMMEDIATE) state_d = (retry_i == RETRY_NONE) ? ST_LATCH : ST_HICCUP;
        end
        ST_DELAY: begin
          if (!fault_i)        state_d = ST_RUN;
          else if (tmr_done_i) state_d = shut_st;
        end
        ST_HICCUP: if (tmr_done_i) begin
          state_d = ST_START;
          if (retry_s != RETRY_FOREVER) att_d = att_q + FLD_W'(1);
        end
        ST_START: begin
          if (fault_i) state_d = shut_st;
          else if (startup_done_i) begin
            state_d = ST_RUN;
            att_d   = '0;
          end
        end
        ST_LATCH: state_d = ST_LATCH;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      att_q   <= '0;
      retry_s <= '0;
      code_s  <= '0;
    end else begin
      state_q <= state_d;
      att_q   <= att_d;
      if (enable_i && fault_i && state_q == ST_RUN) begin
        retry_s <= retry_i;
        code_s  <= code_i;
      end
    end
  end

  assign code_snap_o = code_s;
  // a hidden attempt keeps the output low while the fault persists
  assign run_o     = (state_q == ST_RUN) || (state_q == ST_DELAY) ||
                     ((state_q == ST_START) && !fault_i);
  assign latched_o = (state_q == ST_LATCH);

  assert_disable_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !run_o && !latched_o);
  assert_ignore_runs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && fault_i && state_q == ST_RUN && mode_i == MODE_IGNORE |=> run_o);
  assert_immediate_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && fault_i && state_q == ST_RUN && mode_i == MODE_IMMEDIATE |=> !run_o);
  assert_delay_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !fault_i && state_q == ST_DELAY |=> state_q == ST_RUN);
  assert_attempt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_s != RETRY_FOREVER |-> att_q <= retry_s);
  assert_latch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o && enable_i |=> latched_o);
  assert_forever_no_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_RUN && retry_s == RETRY_FOREVER && !latched_o |=> !latched_o);
endmodule

// File: rtl/ovp_resp_ctrl.sv
module ovp_resp_ctrl
  import ovp_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = 8'h92
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             cfg_err_o,
  output logic             cfg_alert_o,
  input  logic             enable_i,
  input  logic             fault_i,
  input  logic             sw_tick_i,
  input  logic             ss_tick_i,
  input  logic             startup_done_i,
  output logic             run_o,
  output logic             latched_off_o
);
  logic [CFG_W-1:0] cfg_w;
  logic [FLD_W-1:0] code_snap_w;
  logic [CNT_W-1:0] dly_len_w, hic_len_w, tmr_len_w;
  logic             tmr_tick_w, tmr_clr_w, tmr_done_w;

  ovp_cfg_reg #(.RST_VAL(RST_CFG)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg_w), .err_o(cfg_err_o), .alert_o(cfg_alert_o)
  );

  ovp_cfg_decode u_dec (
    .code_i(code_snap_w), .dly_len_o(dly_len_w), .hic_len_o(hic_len_w)
  );

  ovp_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr_w), .tick_i(tmr_tick_w),
    .len_i(tmr_len_w), .done_o(tmr_done_w)
  );

  ovp_fsm u_fsm (
    .clk_i, .rst_ni, .enable_i, .fault_i, .sw_tick_i, .ss_tick_i, .startup_done_i,
    .mode_i(cfg_w[7:6]), .retry_i(cfg_w[5:3]), .code_i(cfg_w[2:0]),
    .dly_len_i(dly_len_w), .hic_len_i(hic_len_w), .tmr_done_i(tmr_done_w),
    .code_snap_o(code_snap_w), .tmr_tick_o(tmr_tick_w), .tmr_clr_o(tmr_clr_w),
    .tmr_len_o(tmr_len_w), .run_o, .latched_o(latched_off_o)
  );

  assign cfg_o = cfg_w;
endmodule

// File: tb/ovp_resp_ctrl_bench.sv
`timescale 1ns/1ps
module ovp_resp_ctrl_bench;
  localparam int P_IDLE = 0, P_RUN = 1, P_DLY = 2, P_HIC = 3, P_START = 4, P_LATCH = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, en = 1'b0, flt = 1'b0, swt = 1'b0, sst = 1'b0, sd = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] cfg_o;
  logic err_o, alert_o, run_o, lat_o;

  int total = 0, bad = 0, tk = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0] m_cfg = 8'h92;
  logic m_err = 1'b0, m_alert = 1'b0;
  int m_ph = P_IDLE, m_cnt = 0, m_att = 0, m_retry = 0, m_code = 0;

  always #2.5 clk = ~clk;

  ovp_resp_ctrl u_ovp_resp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wd), .cfg_o(cfg_o),
    .cfg_err_o(err_o), .cfg_alert_o(alert_o), .enable_i(en), .fault_i(flt),
    .sw_tick_i(swt), .ss_tick_i(sst), .startup_done_i(sd),
    .run_o(run_o), .latched_off_o(lat_o)
  );

  function automatic int dly_len(int c);
    if (c < 2) return 1;
    if (c < 5) return 3;
    return 7;
  endfunction

  function automatic int hic_len(int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic shut();
    if (m_retry == 0 || (m_retry != 7 && m_att >= m_retry)) m_ph = P_LATCH;
    else begin
      m_ph = P_HIC;
      m_cnt = 0;
    end
  endtask

  task automatic model_upd();
    logic [7:0] old;
    old = m_cfg;
    m_alert = 1'b0;
    if (we) begin
      if (wd[7:6] == 2'b11) begin
        m_err = 1'b1;
        m_alert = 1'b1;
      end else begin
        m_cfg = wd;
        m_err = 1'b0;
      end
    end
    if (!en) begin
      m_ph = P_IDLE;
      m_att = 0;
    end else begin
      case (m_ph)
        P_IDLE: begin m_ph = P_RUN; m_att = 0; end
        P_RUN: if (flt) begin
          m_retry = int'(old[5:3]);
          m_code  = int'(old[2:0]);
          if (old[7:6] == 2'b01) begin m_ph = P_DLY; m_cnt = 0; end
          else if (old[7:6] == 2'b10) shut();
        end
        P_DLY: begin
          if (!flt) m_ph = P_RUN;
          else if (swt) begin
            m_cnt++;
            if (m_cnt >= dly_len(m_code)) shut();
          end
        end
        P_HIC: if (sst) begin
          m_cnt++;
          if (m_cnt >= hic_len(m_code)) begin
            m_ph = P_START;
            if (m_retry != 7) m_att++;
          end
        end
        P_START: begin
          if (flt) shut();
          else if (sd) begin m_ph = P_RUN; m_att = 0; end
        end
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    int exp_run;
    exp_run = (m_ph == P_RUN || m_ph == P_DLY || (m_ph == P_START && !flt)) ? 1 : 0;
    chk("run_o", int'(run_o), exp_run);
    chk("latched_off_o", int'(lat_o), (m_ph == P_LATCH) ? 1 : 0);
    chk("cfg_o", int'(cfg_o), int'(m_cfg));
    chk("cfg_err_o", int'(err_o), int'(m_err));
    chk("cfg_alert_o", int'(alert_o), int'(m_alert));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_upd();
      @(negedge clk);
      compare();
      we = 1'b0;
      tk++;
      swt = (tk % 2 == 0);
      sst = (tk % 4 == 0);
    end
  endtask

  task automatic write(logic [7:0] v);
    we = 1'b1;
    wd = v;
    step();
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    chk("reset cfg R1", int'(cfg_o), 8'h92);
    chk("reset run R12", int'(run_o), 0);
    chk("reset latch R12", int'(lat_o), 0);
    compare();

    cur_req = "R2";                     // refused byte
    write(8'hC5);
    chk("err after bad write R2", int'(err_o), 1);
    chk("cfg kept R2", int'(cfg_o), 8'h92);
    step();
    chk("alert single cycle R2", int'(alert_o), 0);

    cur_req = "R1";
    write(8'h00);                        // ignore, no retry
    chk("good write R1", int'(cfg_o), 8'h00);
    chk("err cleared R1", int'(err_o), 0);

    cur_req = "R12";
    en = 1'b1;
    step();
    chk("run after enable R12", int'(run_o), 1);

    cur_req = "R3";
    flt = 1'b1;
    step(20);
    chk("ignore keeps running R3", int'(run_o), 1);
    flt = 1'b0;
    step(2);

    cur_req = "R5";
    write(8'b01_000_011);                // delayed, retry 0, 3 ticks
    flt = 1'b1;
    step(3);
    flt = 1'b0;
    step(4);
    chk("delay abort R5", int'(run_o), 1);
    cur_req = "R4";
    flt = 1'b1;
    step(20);
    cur_req = "R7";
    chk("latched after delay R7", int'(lat_o), 1);
    chk("off when latched R7", int'(run_o), 0);

    cur_req = "R12";
    en = 1'b0;
    step();
    chk("latch cleared R12", int'(lat_o), 0);
    flt = 1'b0;
    en = 1'b1;
    step(2);

    cur_req = "R6";
    write(8'b10_010_101);                // immediate, 2 retries, hiccup 5
    flt = 1'b1;
    step();
    chk("immediate stop R6", int'(run_o), 0);
    cur_req = "R8";
    step(80);
    chk("latched after counted hidden attempts R8", int'(lat_o), 1);
    cur_req = "R10";
    en = 1'b0; flt = 1'b0;
    step();
    en = 1'b1;
    step(2);

    cur_req = "R13";
    write(8'b01_000_111);                // delayed, 7 ticks
    flt = 1'b1;
    step(2);
    write(8'b01_000_000);                // later write must not shorten sequence
    step(3);
    chk("snapshot kept running R13", int'(run_o), 1);
    step(12);
    chk("latched after snapshot delay R13", int'(lat_o), 1);
    en = 1'b0; flt = 1'b0;
    step();
    en = 1'b1;
    step(2);

    cur_req = "R9";
    write(8'b10_111_001);                // immediate, unlimited, hiccup 1
    flt = 1'b1;
    step(60);
    chk("never latches R9", int'(lat_o), 0);
    flt = 1'b0;
    step(8);
    cur_req = "R11";
    sd = 1'b1;
    step(3);
    chk("restart success R11", int'(run_o), 1);
    sd = 1'b0;

    write(8'b10_001_001);                // one retry
    flt = 1'b1;
    step();
    flt = 1'b0;
    step(10);
    sd = 1'b1;
    step(2);
    sd = 1'b0;
    chk("first recovery R11", int'(run_o), 1);
    flt = 1'b1;
    step();
    flt = 1'b0;
    step(10);
    chk("count cleared, not latched R11", int'(lat_o), 0);
    sd = 1'b1;
    step(3);
    chk("second recovery R11", int'(run_o), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule